// File: doc/BRIEF.md
# Two-Level Variable Occurrence Lookup

This block answers, for one inference engine of a hardware clause-propagation unit, the question "where does this variable occur?". A variable index comes in with a valid strobe. The block returns whether the variable has an occurrence in the engine. When it does, the block also returns the clause identifier and the position of the literal inside that clause. Within one engine a variable sits in at most one clause slot, so each lookup yields at most one answer.

A flat table with one entry per variable would be mostly empty. This block packs the occurrences instead, using an indirection. The upper bits of the variable index select a group entry. A group entry is either marked absent or carries a base pointer. The base pointer plus the low index bits (taken modulo the occurrence table depth) selects an occurrence entry. That entry holds either a hit with its clause and position fields, or a miss. Both tables are synchronous RAMs that are filled through one shared write port. Every lookup takes the same two cycles whatever the table contents, and a new lookup can start in every cycle.

Top module: `occ_lookup`

## Requirements
- R1: While reset is held and in the first cycle after it, resValid and resMatch are low.
- R2: A lookup strobed in cycle k produces resValid high in cycle k+2 only. Strobes in consecutive cycles produce results in consecutive cycles, in strobe order.
- R3: The group entry is selected by index bits [IDX_W-1:OFS_W], and the offset is index bits [OFS_W-1:0].
- R4: Group entry layout: bit [L2_AW] is the present flag and bits [L2_AW-1:0] are the base. A group whose present flag is 0 yields resMatch low, whatever the occurrence table holds.
- R5: The occurrence entry address is (base + offset) modulo 2^L2_AW. A sum past the last entry wraps to the start of the table.
- R6: Occurrence entry layout: bit [CID_W+PID_W] is the hit flag, bits [CID_W+PID_W-1:PID_W] are the clause identifier and bits [PID_W-1:0] are the position. A hit gives resMatch high with those fields. A miss gives resMatch low.
- R7: resMatch is never high while resValid is low. resCid and resPid are zero whenever resMatch is low.
- R8: When wrEn is high, wrSel=0 writes the group entry at wrAddr[L1_AW-1:0] with wrData[L2_AW:0]. wrSel=1 writes the occurrence entry at wrAddr[L2_AW-1:0] with wrData[CID_W+PID_W:0].
- R9: A write to an entry in the same cycle that a lookup reads that entry does not affect that lookup, which sees the old contents. Later lookups see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup strobe |
| lkIndex | input | IDX_W | Variable index to look up |
| wrEn | input | 1 | Table write enable |
| wrSel | input | 1 | Table select: 0 group table, 1 occurrence table |
| wrAddr | input | WR_AW | Write address |
| wrData | input | WR_DW | Write data |
| resValid | output | 1 | Lookup result valid |
| resMatch | output | 1 | Variable has an occurrence |
| resCid | output | CID_W | Clause identifier of the occurrence |
| resPid | output | PID_W | Position of the literal in the clause |

## Verification
A table write and a lookup that reads the same entry can land in the same cycle. For the group table, the collision is provoked by strobing a lookup in the cycle that rewrites its group entry. For the occurrence table, a write to the target occurrence address is placed one cycle after the strobe, which is the cycle in which that entry is read. In each case the result must show the old contents, and a repeated lookup must then show the new contents. The expected values come from a flat per-index model that the bench rebuilds from its own copy of both tables.

// File: rtl/occ_lookup_pkg.sv
package occ_lookup_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic l1We;   // write group table
    logic l2We;   // write occurrence table
    logic l1Rd;   // read group table (stage 1)
    logic l2Rd;   // read occurrence table (stage 2)
  } occStrobe_t;

  typedef enum logic {
    TBL_GROUP = 1'b0,
    TBL_OCC   = 1'b1
  } tblSel_t;

endpackage

// File: rtl/occ_lookup_ctrl.sv
module occ_lookup_ctrl
  import occ_lookup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lkValid,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       l1Present,
  output occStrobe_t strobes,
  output logic       s1Valid,
  output logic       s2Valid
);

  tblSel_t selTbl;
  assign selTbl = tblSel_t'(wrSel);

  // Write decode: exactly one table per write
  always_comb begin
    strobes.l1We = wrEn && (selTbl == TBL_GROUP);
    strobes.l2We = wrEn && (selTbl == TBL_OCC);
    strobes.l1Rd = lkValid;
    // Second level is only read for a group that is present
    strobes.l2Rd = s1Valid && l1Present;
  end

  // Two-stage valid pipeline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= lkValid;
      s2Valid <= s1Valid;
    end
  end

endmodule

// File: rtl/occ_lookup_dp.sv
module occ_lookup_dp
  import occ_lookup_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int OFS_W = 2,
  parameter int L2_AW = 4,
  parameter int CID_W = 4,
  parameter int PID_W = 2,
  parameter int WR_AW = 4,
  parameter int WR_DW = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  occStrobe_t       strobes,
  input  logic             s1Valid,
  input  logic             s2Valid,
  input  logic [IDX_W-1:0] lkIndex,
  input  logic [WR_AW-1:0] wrAddr,
  input  logic [WR_DW-1:0] wrData,
  output logic             l1Present,
  output logic             resMatch,
  output logic [CID_W-1:0] resCid,
  output logic [PID_W-1:0] resPid
);

  localparam int L1_AW    = IDX_W - OFS_W;
  localparam int L1_DEPTH = 1 << L1_AW;
  localparam int L2_DEPTH = 1 << L2_AW;
  localparam int L1_DW    = 1 + L2_AW;
  localparam int L2_DW    = 1 + CID_W + PID_W;
  localparam int HIT_BIT  = CID_W + PID_W;

  // Group table
  logic [L1_DW-1:0] l1Mem [L1_DEPTH];
  logic [L1_DW-1:0] l1Q;
  logic [OFS_W-1:0] off1;
  logic [L1_AW-1:0] grpSel;
  logic [L1_AW-1:0] l1WrAddr;

  assign grpSel   = lkIndex[IDX_W-1:OFS_W];
  assign l1WrAddr = wrAddr[L1_AW-1:0];

  always_ff @(posedge clk) begin
    if (strobes.l1We) l1Mem[l1WrAddr] <= wrData[L1_DW-1:0];
  end

  // Read-before-write: the read takes the old contents
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l1Q  <= '0;
      off1 <= '0;
    end else if (strobes.l1Rd) begin
      l1Q  <= l1Mem[grpSel];
      off1 <= lkIndex[OFS_W-1:0];
    end
  end

  assign l1Present = l1Q[L2_AW];

  // Occurrence table
  logic [L2_DW-1:0] l2Mem [L2_DEPTH];
  logic [L2_DW-1:0] l2Q;
  logic [L2_AW-1:0] offExt;
  logic [L2_AW-1:0] l2RdAddr;
  logic [L2_AW-1:0] l2WrAddr;

  assign offExt   = L2_AW'(off1);
  assign l2RdAddr = l1Q[L2_AW-1:0] + offExt;   // wraps modulo depth
  assign l2WrAddr = wrAddr[L2_AW-1:0];

  always_ff @(posedge clk) begin
    if (strobes.l2We) l2Mem[l2WrAddr] <= wrData[L2_DW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             l2Q <= '0;
    else if (strobes.l2Rd) l2Q <= l2Mem[l2RdAddr];
    else                   l2Q <= '0;   // absent group or idle: no hit
  end

  // Result formatting
  always_comb begin
    resMatch = s2Valid && l2Q[HIT_BIT];
    resCid   = resMatch ? l2Q[HIT_BIT-1:PID_W] : '0;
    resPid   = resMatch ? l2Q[PID_W-1:0]       : '0;
  end

  // R4: an absent group never reports a match
  p_absent_nomatch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !l1Present) |=> !resMatch);

  // R7: a match is only reported with a valid result
  p_match_needs_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    resMatch |-> s2Valid);

  // R7: fields are zero without a match
  p_zero_fields_r7: assert property (@(posedge clk) disable iff (!rstN)
    !resMatch |-> (resCid == '0 && resPid == '0));

endmodule

// File: rtl/occ_lookup.sv
module occ_lookup
  import occ_lookup_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int OFS_W = 2,
  parameter int L2_AW = 4,
  parameter int CID_W = 4,
  parameter int PID_W = 2,
  parameter int WR_AW = (IDX_W - OFS_W) > L2_AW ? (IDX_W - OFS_W) : L2_AW,
  parameter int WR_DW = (1 + L2_AW) > (1 + CID_W + PID_W) ? (1 + L2_AW) : (1 + CID_W + PID_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [IDX_W-1:0] lkIndex,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [WR_AW-1:0] wrAddr,
  input  logic [WR_DW-1:0] wrData,
  output logic             resValid,
  output logic             resMatch,
  output logic [CID_W-1:0] resCid,
  output logic [PID_W-1:0] resPid
);

  occStrobe_t strobes;
  logic       s1Valid;
  logic       s2Valid;
  logic       l1Present;

  occ_lookup_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lkValid   (lkValid),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .l1Present (l1Present),
    .strobes   (strobes),
    .s1Valid   (s1Valid),
    .s2Valid   (s2Valid)
  );

  occ_lookup_dp #(
    .IDX_W (IDX_W),
    .OFS_W (OFS_W),
    .L2_AW (L2_AW),
    .CID_W (CID_W),
    .PID_W (PID_W),
    .WR_AW (WR_AW),
    .WR_DW (WR_DW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .s1Valid   (s1Valid),
    .s2Valid   (s2Valid),
    .lkIndex   (lkIndex),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .l1Present (l1Present),
    .resMatch  (resMatch),
    .resCid    (resCid),
    .resPid    (resPid)
  );

  assign resValid = s2Valid;

  // R2: every valid result stems from a strobe two cycles earlier
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(lkValid, 2));

endmodule

// File: tb/tb_occ_lookup.sv
module tb_occ_lookup;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int OFS_W = 2;
  localparam int L2_AW = 4;
  localparam int CID_W = 4;
  localparam int PID_W = 2;
  localparam int WR_AW = 4;
  localparam int WR_DW = 7;
  localparam int NIDX  = 1 << IDX_W;
  localparam int NGRP  = 1 << (IDX_W - OFS_W);
  localparam int NOCC  = 1 << L2_AW;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             lkValid = 1'b0;
  logic [IDX_W-1:0] lkIndex = '0;
  logic             wrEn = 1'b0;
  logic             wrSel = 1'b0;
  logic [WR_AW-1:0] wrAddr = '0;
  logic [WR_DW-1:0] wrData = '0;
  logic             resValid;
  logic             resMatch;
  logic [CID_W-1:0] resCid;
  logic [PID_W-1:0] resPid;

  int checks = 0;
  int errors = 0;

  // Bench copies of both tables
  logic [4:0] mGrp [NGRP];
  logic [6:0] mOcc [NOCC];

  occ_lookup dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkIndex(lkIndex),
    .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData),
    .resValid(resValid), .resMatch(resMatch), .resCid(resCid), .resPid(resPid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Flat reference: {valid, match, cid, pid} for an index
  function automatic logic [7:0] flatOf(int idx);
    logic [4:0] g;
    logic [3:0] a;
    logic [6:0] e;
    g = mGrp[idx >> OFS_W];
    if (!g[4]) return 8'h80;
    a = g[3:0] + 4'(idx & 3);
    e = mOcc[a];
    if (!e[6]) return 8'h80;
    return {1'b1, e};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {resValid, resMatch, resCid, resPid};
  endfunction

  task automatic writeTbl(logic sel, int addr, logic [6:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrAddr = WR_AW'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (sel) mOcc[addr] = data; else mGrp[addr] = data[4:0];
  endtask

  // Single lookup, checked two cycles after the strobe
  task automatic lookOne(string req, int idx);
    @(negedge clk);
    lkValid = 1'b1; lkIndex = IDX_W'(idx);
    @(negedge clk);
    lkValid = 1'b0;
    chk({req, " early"}, {7'b0, resValid}, 8'h00);
    @(negedge clk);
    chk(req, outs(), flatOf(idx));
    @(negedge clk);
    chk({req, " single pulse"}, {7'b0, resValid}, 8'h00);
  endtask

  task automatic testReset();
    chk("R1 in reset", {6'b0, resValid, resMatch}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {6'b0, resValid, resMatch}, 8'h00);
  endtask

  task automatic loadTables();
    for (int a = 0; a < NOCC; a++) writeTbl(1'b1, a, 7'h00);
    writeTbl(1'b1, 5,  {1'b1, 4'd1, 2'd1});
    writeTbl(1'b1, 6,  {1'b1, 4'd7, 2'd0});
    writeTbl(1'b1, 8,  {1'b1, 4'd2, 2'd1});
    writeTbl(1'b1, 9,  {1'b1, 4'd2, 2'd2});
    writeTbl(1'b1, 10, {1'b1, 4'd1, 2'd2});
    writeTbl(1'b1, 1,  {1'b1, 4'd3, 2'd3});
    writeTbl(1'b0, 0, {2'b0, 1'b1, 4'd4});   // group 0 base 4
    writeTbl(1'b0, 1, {2'b0, 1'b0, 4'd5});   // group 1 absent, base aims at hits
    writeTbl(1'b0, 2, {2'b0, 1'b1, 4'd8});   // group 2 base 8
    writeTbl(1'b0, 3, {2'b0, 1'b1, 4'd14});  // group 3 base 14, wraps
  endtask

  task automatic testSingles();
    lookOne("R6 hit idx1", 1);
    lookOne("R6 miss idx0", 0);
    lookOne("R3 group2 idx9", 9);
    lookOne("R4 absent idx5", 5);
    lookOne("R4 absent idx6", 6);
    lookOne("R5 wrap idx15", 15);
    lookOne("R5 wrap miss idx12", 12);
  endtask

  // Back-to-back sweep of every index vs. the flat model
  task automatic testSweep();
    for (int i = 0; i < NIDX + 2; i++) begin
      @(negedge clk);
      if (i >= 2) chk($sformatf("R2 R7 sweep idx%0d", i - 2), outs(), flatOf(i - 2));
      lkValid = (i < NIDX);
      lkIndex = IDX_W'(i);
    end
    lkValid = 1'b0;
    @(negedge clk);
    chk("R2 idle after sweep", {7'b0, resValid}, 8'h00);
  endtask

  task automatic testCollideGroup();
    logic [7:0] oldExp;
    oldExp = flatOf(9);
    @(negedge clk);
    lkValid = 1'b1; lkIndex = 4'd9;
    wrEn = 1'b1; wrSel = 1'b0; wrAddr = 4'd2; wrData = {2'b0, 1'b0, 4'd8};
    @(negedge clk);
    lkValid = 1'b0; wrEn = 1'b0;
    mGrp[2] = 5'b0_1000;
    @(negedge clk);
    chk("R9 group write same cycle", outs(), oldExp);
    lookOne("R9 group write later", 9);
    writeTbl(1'b0, 2, {2'b0, 1'b1, 4'd8});
    lookOne("R8 group restored", 9);
  endtask

  task automatic testCollideOcc();
    logic [7:0] oldExp;
    oldExp = flatOf(8);
    @(negedge clk);
    lkValid = 1'b1; lkIndex = 4'd8;
    @(negedge clk);
    lkValid = 1'b0;
    wrEn = 1'b1; wrSel = 1'b1; wrAddr = 4'd8; wrData = {1'b1, 4'd11, 2'd3};
    @(negedge clk);
    wrEn = 1'b0;
    mOcc[8] = {1'b1, 4'd11, 2'd3};
    chk("R9 occurrence write same cycle", outs(), oldExp);
    lookOne("R9 occurrence write later", 8);
    chk("R8 occurrence new fields", flatOf(8), 8'hEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    loadTables();
    testSingles();
    testSweep();
    testCollideGroup();
    testCollideOcc();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule